// File: doc/BRIEF.md
# DDR2 Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 memory interface. It brings the device from power-on to a usable state by issuing the required command sequence on the clock-enable, command, bank-address and address pins. The command order is fixed. The spacing between commands comes from parameters expressed in controller clock cycles. The operating mode-register contents (burst length, CAS latency, additive latency, termination and so on) arrive as four configuration words. The sequencer overrides only the bits that the start-up procedure itself dictates.

The sequence runs as follows:
1. Clock enable is held low for a power-up interval, then raised.
2. The device idles on NOP, then receives a precharge-all.
3. Extended registers 2, 3 and 1 are written, with extended register 1 written to enable the DLL.
4. The main register is written with the DLL-reset bit set.
5. A second precharge-all is issued, followed by a programmable number of auto-refresh commands.
6. The main register is written again with the DLL-reset bit clear.
7. Once a relock window has elapsed since the DLL reset, extended register 1 is written twice: first with its calibration field at all ones, then with that field at all zeros.

A done flag rises a fixed gap after the last write. Every cycle that carries no command drives NOP. Reset restarts everything from the clock-enable-low state.

Top module: `ddr2_init_seq`

## Requirements
- R1: While reset is low, and after any reset, the outputs are: `cke`=0, NOP on the pins (`cs_n,ras_n,cas_n,we_n` = 0,1,1,1), `init_done`=0. Releasing reset restarts the sequence from the start, even after a reset in the middle of a run.
- R2: `cke` rises exactly T_PWRUP clock edges after reset release. It stays low before that and high afterwards. No command other than NOP appears while it is low.
- R3: Precharge-all is issued T_CKE_NOP cycles after `cke` rises. It is encoded as pins 0,0,1,0 with address bit 10 set, all other address bits 0, and bank 0.
- R4: A mode-register write is encoded as pins 0,0,0,0. The first write goes to bank 2 with `cfg_emr2`, T_RP cycles after the precharge. The next goes to bank 3 with `cfg_emr3`.
- R5: The third write goes to bank 1. It carries `cfg_emr1` with bit 0 forced to 0 (DLL enabled) and bits 9:7 forced to 0.
- R6: The fourth write goes to bank 0 with `cfg_mr` and bit 8 forced to 1 (DLL reset). A precharge-all follows T_MRD later. REF_COUNT auto-refreshes (pins 0,0,0,1, bank 0, address 0) follow, the first T_RP after the precharge and the rest T_RFC apart.
- R7: T_RFC after the last refresh, bank 0 is written with `cfg_mr` and bit 8 forced to 0.
- R8: Bank 1 is then written with `cfg_emr1` and bits 9:7 forced to 111. This write comes no earlier than RELOCK_CYCLES after the DLL-reset write and no earlier than T_MRD after the previous write. It is issued at the later of those two points.
- R9: T_MRD later, bank 1 is written with `cfg_emr1` and bits 9:7 forced to 000. All other fields come from the input.
- R10: The top address bit (bit ADDR_W-1, bit 13 by default) is 0 in every mode-register write.
- R11: Consecutive commands are exactly the stated number of cycles apart, and every cycle between them drives NOP.
- R12: `init_done` rises exactly T_MRD cycles after the final write. It then stays high, and only NOP is driven from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset; restarts the sequence |
| cfg_mr | input | ADDR_W | Operating main mode-register word |
| cfg_emr1 | input | ADDR_W | Operating extended register 1 word |
| cfg_emr2 | input | ADDR_W | Extended register 2 word |
| cfg_emr3 | input | ADDR_W | Extended register 3 word |
| cke | output | 1 | Clock enable to the device |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address |
| addr | output | ADDR_W | Address / mode-register payload |
| init_done | output | 1 | High once initialization is complete |

## Verification
The hardest case to reach is the point where the relock window, not the normal write spacing, decides when the calibration-set write is issued. That window runs concurrently with the precharge, refresh and mode-register steps, so its effect shows up only as a stretched gap before one particular write. The bench uses a relock length longer than the chain of steps that follows the DLL reset. It computes the stretched gap from the parameters and compares it with the measured distance between commands. It also asserts reset in the middle of the extended-register writes and checks that a full, correctly timed run follows.

// File: rtl/ddr2i_pkg.sv
package ddr2i_pkg;

    typedef enum logic [3:0] {
        ST_PWRUP,
        ST_PREA_A,
        ST_EMR2,
        ST_EMR3,
        ST_EMR1_DLL,
        ST_MR_RST,
        ST_PREA_B,
        ST_REF,
        ST_MR_OP,
        ST_EMR1_SET,
        ST_EMR1_CLR,
        ST_FINISH,
        ST_IDLE
    } seq_state_e;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PREA,
        CMD_REF,
        CMD_MODE
    } dram_cmd_e;

    // Address bit positions that the device decodes during start-up
    localparam int BIT_DLL_OFF = 0;
    localparam int BIT_OCD_LO  = 7;
    localparam int BIT_DLL_RST = 8;
    localparam int BIT_OCD_HI  = 9;
    localparam int BIT_ALLBANK = 10;

endpackage

// File: rtl/ddr2i_wait_timer.sv
module ddr2i_wait_timer #(
    parameter int             W       = 8,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= RST_VAL;
        else        cnt_q <= cnt_d;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/ddr2i_cmd_enc.sv
module ddr2i_cmd_enc
    import ddr2i_pkg::*;
(
    input  dram_cmd_e   cmd,
    output logic [3:0]  pins   // {cs_n, ras_n, cas_n, we_n}
);
    always_comb begin
        case (cmd)
            CMD_PREA: pins = 4'b0010;
            CMD_REF:  pins = 4'b0001;
            CMD_MODE: pins = 4'b0000;
            default:  pins = 4'b0111;
        endcase
    end
endmodule

// File: rtl/ddr2_init_seq.sv
module ddr2_init_seq
    import ddr2i_pkg::*;
#(
    parameter int ADDR_W        = 14,
    parameter int T_PWRUP       = 40000,
    parameter int T_CKE_NOP     = 80,
    parameter int T_RP          = 3,
    parameter int T_MRD         = 2,
    parameter int T_RFC         = 26,
    parameter int RELOCK_CYCLES = 200,
    parameter int REF_COUNT     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_mr,
    input  logic [ADDR_W-1:0] cfg_emr1,
    input  logic [ADDR_W-1:0] cfg_emr2,
    input  logic [ADDR_W-1:0] cfg_emr3,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [2:0]        ba,
    output logic [ADDR_W-1:0] addr,
    output logic              init_done
);
    localparam int M1       = (T_PWRUP > T_CKE_NOP) ? T_PWRUP : T_CKE_NOP;
    localparam int M2       = (T_RP > T_MRD) ? T_RP : T_MRD;
    localparam int M3       = (M2 > T_RFC) ? M2 : T_RFC;
    localparam int MAX_WAIT = (M1 > M3) ? M1 : M3;
    localparam int CNT_W    = $clog2(MAX_WAIT + 1);
    localparam int RL_W     = $clog2(RELOCK_CYCLES + 1);
    localparam int REF_W    = $clog2(REF_COUNT + 1);
    localparam int TOP_BIT  = ADDR_W - 1;

    typedef struct packed {
        seq_state_e        state;
        logic              cke;
        logic [3:0]        pins;
        logic [2:0]        ba;
        logic [ADDR_W-1:0] addr;
        logic              done;
        logic [REF_W-1:0]  ref_left;
    } seq_regs_t;

    seq_regs_t   r_d, r_q;
    dram_cmd_e   cmd;
    logic [3:0]  enc_pins;
    logic        wt_load, wt_zero, rl_load, rl_zero, go;
    logic [CNT_W-1:0] wt_val;
    logic [2:0]        ba_n;
    logic [ADDR_W-1:0] addr_n;
    logic [ADDR_W-1:0] w_mr, w_e1, w_e2, w_e3;

    ddr2i_wait_timer #(.W(CNT_W), .RST_VAL(CNT_W'(T_PWRUP - 1))) u_gap (
        .clk(clk), .rst_n(rst_n), .load(wt_load), .load_val(wt_val), .zero(wt_zero)
    );

    ddr2i_wait_timer #(.W(RL_W), .RST_VAL('0)) u_relock (
        .clk(clk), .rst_n(rst_n), .load(rl_load),
        .load_val(RL_W'(RELOCK_CYCLES - 1)), .zero(rl_zero)
    );

    ddr2i_cmd_enc u_enc (.cmd(cmd), .pins(enc_pins));

    always_comb begin
        // reserved top bit is always written as zero
        w_mr = cfg_mr;     w_mr[TOP_BIT] = 1'b0;
        w_e1 = cfg_emr1;   w_e1[TOP_BIT] = 1'b0;
        w_e2 = cfg_emr2;   w_e2[TOP_BIT] = 1'b0;
        w_e3 = cfg_emr3;   w_e3[TOP_BIT] = 1'b0;

        r_d     = r_q;
        cmd     = CMD_NOP;
        ba_n    = 3'd0;
        addr_n  = '0;
        wt_load = 1'b0;
        wt_val  = '0;
        rl_load = 1'b0;
        go      = wt_zero && ((r_q.state != ST_EMR1_SET) || rl_zero);

        if (go) begin
            case (r_q.state)
                ST_PWRUP: begin
                    r_d.cke   = 1'b1;
                    wt_load   = 1'b1;
                    wt_val    = CNT_W'(T_CKE_NOP - 1);
                    r_d.state = ST_PREA_A;
                end
                ST_PREA_A, ST_PREA_B: begin
                    cmd                 = CMD_PREA;
                    addr_n[BIT_ALLBANK] = 1'b1;
                    wt_load             = 1'b1;
                    wt_val              = CNT_W'(T_RP - 1);
                    r_d.ref_left        = REF_W'(REF_COUNT);
                    r_d.state           = (r_q.state == ST_PREA_A) ? ST_EMR2 : ST_REF;
                end
                ST_EMR2: begin
                    cmd = CMD_MODE; ba_n = 3'd2; addr_n = w_e2;
                    wt_load = 1'b1; wt_val = CNT_W'(T_MRD - 1);
                    r_d.state = ST_EMR3;
                end
                ST_EMR3: begin
                    cmd = CMD_MODE; ba_n = 3'd3; addr_n = w_e3;
                    wt_load = 1'b1; wt_val = CNT_W'(T_MRD - 1);
                    r_d.state = ST_EMR1_DLL;
                end
                ST_EMR1_DLL: begin
                    cmd = CMD_MODE; ba_n = 3'd1; addr_n = w_e1;
                    addr_n[BIT_DLL_OFF] = 1'b0;
                    addr_n[BIT_OCD_HI:BIT_OCD_LO] = 3'b000;
                    wt_load = 1'b1; wt_val = CNT_W'(T_MRD - 1);
                    r_d.state = ST_MR_RST;
                end
                ST_MR_RST: begin
                    cmd = CMD_MODE; ba_n = 3'd0; addr_n = w_mr;
                    addr_n[BIT_DLL_RST] = 1'b1;
                    wt_load = 1'b1; wt_val = CNT_W'(T_MRD - 1);
                    rl_load = 1'b1;
                    r_d.state = ST_PREA_B;
                end
                ST_REF: begin
                    cmd = CMD_REF;
                    wt_load = 1'b1; wt_val = CNT_W'(T_RFC - 1);
                    r_d.ref_left = r_q.ref_left - REF_W'(1);
                    if (r_q.ref_left <= REF_W'(1)) r_d.state = ST_MR_OP;
                end
                ST_MR_OP: begin
                    cmd = CMD_MODE; ba_n = 3'd0; addr_n = w_mr;
                    addr_n[BIT_DLL_RST] = 1'b0;
                    wt_load = 1'b1; wt_val = CNT_W'(T_MRD - 1);
                    r_d.state = ST_EMR1_SET;
                end
                ST_EMR1_SET, ST_EMR1_CLR: begin
                    cmd = CMD_MODE; ba_n = 3'd1; addr_n = w_e1;
                    addr_n[BIT_OCD_HI:BIT_OCD_LO] =
                        (r_q.state == ST_EMR1_SET) ? 3'b111 : 3'b000;
                    wt_load = 1'b1; wt_val = CNT_W'(T_MRD - 1);
                    r_d.state = (r_q.state == ST_EMR1_SET) ? ST_EMR1_CLR : ST_FINISH;
                end
                ST_FINISH: begin
                    r_d.done  = 1'b1;
                    r_d.state = ST_IDLE;
                end
                default: ;
            endcase
        end

        r_d.pins = enc_pins;
        r_d.ba   = ba_n;
        r_d.addr = addr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state    <= ST_PWRUP;
            r_q.cke      <= 1'b0;
            r_q.pins     <= 4'b0111;
            r_q.ba       <= 3'd0;
            r_q.addr     <= '0;
            r_q.done     <= 1'b0;
            r_q.ref_left <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cke                      = r_q.cke;
    assign {cs_n, ras_n, cas_n, we_n} = r_q.pins;
    assign ba                       = r_q.ba;
    assign addr                     = r_q.addr;
    assign init_done                = r_q.done;
endmodule

// File: rtl/ddr2_init_seq_chk.sv
module ddr2_init_seq_chk #(
    parameter int T_MRD         = 2,
    parameter int RELOCK_CYCLES = 200
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cke,
    input logic       cs_n,
    input logic       ras_n,
    input logic       cas_n,
    input logic       we_n,
    input logic [2:0] ba,
    input logic       a_top,
    input logic       a_dllrst,
    input logic [2:0] a_ocd,
    input logic       init_done
);
    localparam int SW = $clog2(RELOCK_CYCLES + 1) + 1;

    logic is_nop, is_mode, dll_rst_wr, ocd_set_wr;
    logic [SW-1:0] since_q;

    assign is_nop     = ({cs_n, ras_n, cas_n, we_n} == 4'b0111);
    assign is_mode    = ({cs_n, ras_n, cas_n, we_n} == 4'b0000);
    assign dll_rst_wr = is_mode && (ba == 3'd0) && a_dllrst;
    assign ocd_set_wr = is_mode && (ba == 3'd1) && (a_ocd == 3'b111);

    // cycles since the DLL-reset write, saturating at the relock length
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            since_q <= '0;
        else if (dll_rst_wr)
            since_q <= SW'(1);
        else if (since_q != '0 && since_q < SW'(RELOCK_CYCLES))
            since_q <= since_q + SW'(1);
    end

    // R2: clock enable never drops once raised
    p_cke_stays_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cke |=> cke);

    // R2: only NOP while clock enable is low
    p_nop_cke_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !cke |-> is_nop);

    // R10: reserved top bit zero in every mode write
    p_top_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
        is_mode |-> !a_top);

    // R11: back-to-back mode writes never occur when spacing exceeds one
    p_mode_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (T_MRD > 1 && is_mode) |=> !is_mode);

    // R8: calibration-set write only after the relock window
    p_relock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ocd_set_wr |-> (since_q >= SW'(RELOCK_CYCLES)));

    // R12: done is sticky and quiet
    p_done_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> init_done);
    p_done_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |-> is_nop);
endmodule

bind ddr2_init_seq ddr2_init_seq_chk #(
    .T_MRD(T_MRD), .RELOCK_CYCLES(RELOCK_CYCLES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cke(cke),
    .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .a_top(addr[ADDR_W-1]), .a_dllrst(addr[8]), .a_ocd(addr[9:7]),
    .init_done(init_done)
);

// File: tb/ddr2_init_seq_test.sv
`timescale 1ns/1ps
module ddr2_init_seq_test;
    localparam int AW   = 14;
    localparam int P    = 30;
    localparam int Q    = 16;
    localparam int RP   = 3;
    localparam int MRD  = 2;
    localparam int RFC  = 9;
    localparam int RL   = 40;
    localparam int NREF = 2;

    localparam logic [AW-1:0] A13M = 14'h2000;
    localparam logic [AW-1:0] A8M  = 14'h0100;
    localparam logic [AW-1:0] A97M = 14'h0380;
    localparam logic [AW-1:0] A0M  = 14'h0001;
    localparam logic [AW-1:0] A10M = 14'h0400;

    localparam logic [AW-1:0] C_MR = 14'h2B53;
    localparam logic [AW-1:0] C_E1 = 14'h2785;
    localparam logic [AW-1:0] C_E2 = 14'h2080;
    localparam logic [AW-1:0] C_E3 = 14'h3003;

    localparam int CHAIN   = MRD + RP + RFC + RFC;
    localparam int REL_GAP = (RL - CHAIN > MRD) ? (RL - CHAIN) : MRD;

    localparam logic [3:0] PN = 4'b0111, PP = 4'b0010, PR = 4'b0001, PM = 4'b0000;

    // {pins, ba, addr, gap}
    localparam int NE = 11;
    localparam logic [36:0] EXP [NE] = '{
        {PP, 3'd0, A10M,                       16'(Q)},
        {PM, 3'd2, C_E2 & ~A13M,               16'(RP)},
        {PM, 3'd3, C_E3 & ~A13M,               16'(MRD)},
        {PM, 3'd1, C_E1 & ~(A13M | A97M | A0M), 16'(MRD)},
        {PM, 3'd0, (C_MR | A8M) & ~A13M,       16'(MRD)},
        {PP, 3'd0, A10M,                       16'(MRD)},
        {PR, 3'd0, 14'h0000,                   16'(RP)},
        {PR, 3'd0, 14'h0000,                   16'(RFC)},
        {PM, 3'd0, C_MR & ~(A8M | A13M),       16'(RFC)},
        {PM, 3'd1, (C_E1 & ~A13M) | A97M,      16'(REL_GAP)},
        {PM, 3'd1, C_E1 & ~(A13M | A97M),      16'(MRD)}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic cke, cs_n, ras_n, cas_n, we_n, init_done;
    logic [2:0] ba;
    logic [AW-1:0] addr;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    ddr2_init_seq #(
        .ADDR_W(AW), .T_PWRUP(P), .T_CKE_NOP(Q), .T_RP(RP), .T_MRD(MRD),
        .T_RFC(RFC), .RELOCK_CYCLES(RL), .REF_COUNT(NREF)
    ) uut (
        .clk(clk), .rst_n(rst_n), .cfg_mr(C_MR), .cfg_emr1(C_E1),
        .cfg_emr2(C_E2), .cfg_emr3(C_E3), .cke(cke), .cs_n(cs_n),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
        .init_done(init_done)
    );

    function automatic string tag_of(input int i);
        case (i)
            0:       return "R3";
            1, 2:    return "R4";
            3:       return "R5";
            4, 5, 6, 7: return "R6";
            8:       return "R7";
            9:       return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {cs_n, ras_n, cas_n, we_n};
    endfunction

    task automatic walk();
        int cyc = 0, last;
        bit bad_low = 0, bad_high = 0, timeout = 0;
        // R2: clock enable rise
        while (!cke && cyc < P + 100) begin
            @(posedge clk); cyc++;
            @(negedge clk);
            if (!cke && pins() != PN) bad_low = 1;
        end
        check(cyc == P && !bad_low, "R2", "cke rise edge count", 64'(cyc), 64'(P));
        last = cyc;
        for (int i = 0; i < NE; i++) begin
            int start = cyc;
            do begin
                @(posedge clk); cyc++;
                @(negedge clk);
                if (!cke) bad_high = 1;
                if (init_done) bad_high = 1;
                if (cyc - start > 1000) timeout = 1;
            end while (pins() == PN && !timeout);
            // R11: exact gap and NOP between commands; field checks per requirement
            check({pins(), ba, addr, 16'(cyc - last)} == EXP[i] && !timeout,
                  tag_of(i), $sformatf("entry %0d {pins,ba,addr,gap}", i),
                  64'({pins(), ba, addr, 16'(cyc - last)}), 64'(EXP[i]));
            last = cyc;
        end
        check(!bad_high, "R2", "cke high / done low during run", 64'(bad_high), 64'(0));
        begin
            int g = 0;
            while (!init_done && g < 100) begin
                @(posedge clk); g++;
                @(negedge clk);
                if (pins() != PN) bad_high = 1;
            end
            check(g == MRD && !bad_high, "R12", "done gap after final write",
                  64'(g), 64'(MRD));
        end
        begin
            bit quiet = 1;
            for (int k = 0; k < 20; k++) begin
                @(posedge clk); @(negedge clk);
                if (!init_done || pins() != PN || !cke) quiet = 0;
            end
            check(quiet, "R12", "done sticky and NOP afterwards", 64'(quiet), 64'(1));
        end
    endtask

    task automatic check_reset_state(input string what);
        check(cke == 1'b0 && pins() == PN && init_done == 1'b0, "R1", what,
              64'({cke, pins(), init_done}), 64'({1'b0, PN, 1'b0}));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state("state in reset");
        rst_n = 1'b1;
        walk();

        // R1: reset in the middle of the extended-register writes
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        repeat (P + Q + 4) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check_reset_state("async reset mid-sequence");
        @(negedge clk);
        check_reset_state("held reset mid-sequence");
        rst_n = 1'b1;
        walk();

        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        #(20000 * 5);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule